// File: doc/BRIEF.md
# Programmable Parallel Port Interface

A bus-attached parallel I/O unit with three 8-bit ports, A, B and C, and one control register. A CPU reaches the unit through a 2-bit address, a chip select, a read strobe and a write strobe. Write data and read data use separate 8-bit buses. Each port pin is modelled as an input bit, an output bit and an output-enable bit. The unit does simple input and output with no handshaking.

The control address takes two kinds of word, and bit 7 tells them apart. A word with bit 7 set is a mode definition word. It sets the direction of port A, port B and each half of port C, and it clears every output latch. A word with bit 7 clear is a single-bit command that sets or clears one port C latch bit. The other seven port C bits keep their values. Port writes load the selected latch. Port reads return the latch for a port that is an output and the live pins for a port that is an input.

Top module: `pio_unit`

## Requirements
- R1: After reset every port is an input: all output enables are 0, all output latches are 0, and reading the control address returns 0x9B.
- R2: Address 00 selects port A, 01 selects port B, 10 selects port C and 11 selects the control register. Any access needs `cs`=1 together with `wr` or `rd`.
- R3: A control write with bit 7 = 1 sets the directions, where 1 means input. Bit 4 sets port A, bit 1 sets port B, bit 3 sets port C bits 7..4 and bit 0 sets port C bits 3..0. From the next cycle each output-enable bit is the inverse of its direction bit. For example, 0x80 makes every port an output.
- R4: A control write with bit 7 = 1 clears the A, B and C output latches to 0.
- R5: A control write with bit 7 = 0 changes one port C latch bit. Bits 3..1 select the bit and bit 0 gives its new value. The other port C latch bits are unchanged. For example, 0x07 sets bit 3.
- R6: A read of a port returns its latch when the port is an output and its input pins when it is an input. Each half of port C is chosen by that half's own direction.
- R7: A write to a port address loads that port's latch, which appears on the port's output bus from the next cycle. The pins are driven only where the output enable is 1.
- R8: A read of the control address returns {1, 2'b00, A dir, C-upper dir, 1'b0, B dir, C-lower dir}.
- R9: When `cs`=0, writes change no latch and no direction, and `rdata` is 0. `rdata` is also 0 when `rd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The mode words tried are all-input (the reset state), all-output (0x80), C upper in with C lower out (0x88), and A, B in with C out (0x92). Comparing reads and enables across these words shows whether each direction bit is wired to the right port or half. Single-bit commands set and clear bits 3, 7 and 0, and the test checks the full port C value each time. This separates the bit index from the value bit and catches any disturbance of the other bits. The pin and latch values are distinct, so a port read shows which source it was taken from. Writes with `cs` low and a repeated mode word show the guarding and latch clearing.

// File: rtl/pio_unit.sv
module pio_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);
  logic [7:0] lat_a, lat_b, lat_c;
  logic       a_in, b_in, cu_in, cl_in;

  logic wr_en, rd_en, mode_wr, bit_wr;
  assign wr_en   = cs & wr;
  assign rd_en   = cs & rd;
  assign mode_wr = wr_en & (addr == 2'b11) &  wdata[7];
  assign bit_wr  = wr_en & (addr == 2'b11) & ~wdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
      a_in  <= 1'b1;
      b_in  <= 1'b1;
      cu_in <= 1'b1;
      cl_in <= 1'b1;
    end else if (mode_wr) begin
      a_in  <= wdata[4];
      cu_in <= wdata[3];
      b_in  <= wdata[1];
      cl_in <= wdata[0];
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else if (bit_wr) begin
      lat_c[wdata[3:1]] <= wdata[0];
    end else if (wr_en) begin
      case (addr)
        2'b00:   lat_a <= wdata;
        2'b01:   lat_b <= wdata;
        2'b10:   lat_c <= wdata;
        default: ;
      endcase
    end
  end

  assign pa_out = lat_a;
  assign pb_out = lat_b;
  assign pc_out = lat_c;
  assign pa_oe  = {8{~a_in}};
  assign pb_oe  = {8{~b_in}};
  assign pc_oe  = {{4{~cu_in}}, {4{~cl_in}}};

  logic [7:0] view_a, view_b, view_c, view_ctl;
  assign view_a   = a_in ? pa_in : lat_a;
  assign view_b   = b_in ? pb_in : lat_b;
  assign view_c   = {cu_in ? pc_in[7:4] : lat_c[7:4], cl_in ? pc_in[3:0] : lat_c[3:0]};
  assign view_ctl = {3'b100, a_in, cu_in, 1'b0, b_in, cl_in};

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        2'b00:   rdata = view_a;
        2'b01:   rdata = view_b;
        2'b10:   rdata = view_c;
        default: rdata = view_ctl;
      endcase
    end
  end
endmodule

// File: rtl/pio_unit_chk.sv
module pio_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       rd,
  input logic       wr,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] pa_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_out,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_out,
  input logic [7:0] pc_oe
);
  logic ctl_wr;
  assign ctl_wr = cs && wr && addr == 2'b11;

  assert_mode_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && wdata[7] |=> pa_oe == {8{~$past(wdata[4])}} && pb_oe == {8{~$past(wdata[1])}} &&
      pc_oe == {{4{~$past(wdata[3])}}, {4{~$past(wdata[0])}}});

  assert_mode_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && wdata[7] |=> pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00);

  assert_bit_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !wdata[7] |=>
      (((pc_out ^ $past(pc_out)) & ~(8'h01 << $past(wdata[3:1]))) == 8'h00) &&
      (((pc_out >> $past(wdata[3:1])) & 8'h01) == {7'b0, $past(wdata[0])}));

  assert_no_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
      $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe));

  assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> rdata == 8'h00);
endmodule

bind pio_unit pio_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pa_out(pa_out), .pa_oe(pa_oe),
  .pb_out(pb_out), .pb_oe(pb_oe), .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/sim_pio_unit.sv
module sim_pio_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cs = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [7:0] pa_in = 8'h5A, pb_in = 8'hE1, pc_in = 8'h3C;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_unit u0 (.clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in), .pc_out(pc_out),
    .pc_oe(pc_oe));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d, logic sel = 1);
    @(negedge clk); cs = sel; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d, input logic sel = 1);
    @(negedge clk); cs = sel; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 pc_out", pc_out, 8'h00);
    bus_rd(2'b11, d); chk("R1 ctl read", d, 8'h9B);
    bus_rd(2'b00, d); chk("R6 A input read", d, 8'h5A);
    bus_rd(2'b10, d); chk("R6 C input read", d, 8'h3C);
  endtask

  task automatic t_all_out;
    logic [7:0] d;
    bus_wr(2'b11, 8'h80);
    chk("R3 pa_oe", pa_oe, 8'hFF);
    chk("R3 pb_oe", pb_oe, 8'hFF);
    chk("R3 pc_oe", pc_oe, 8'hFF);
    bus_rd(2'b11, d); chk("R8 ctl read 80", d, 8'h80);
    bus_wr(2'b00, 8'h3C); bus_wr(2'b01, 8'hC3); bus_wr(2'b10, 8'h81);
    chk("R7 pa_out", pa_out, 8'h3C);
    chk("R7 pb_out", pb_out, 8'hC3);
    chk("R2 pc_out", pc_out, 8'h81);
    bus_rd(2'b00, d); chk("R6 A latch read", d, 8'h3C);
    bus_rd(2'b01, d); chk("R2 B latch read", d, 8'hC3);
    bus_rd(2'b10, d); chk("R2 C latch read", d, 8'h81);
  endtask

  task automatic t_bits;
    bus_wr(2'b11, 8'h07); chk("R5 set bit3", pc_out, 8'h89);
    bus_wr(2'b11, 8'h0E); chk("R5 clear bit7", pc_out, 8'h09);
    bus_wr(2'b11, 8'h00); chk("R5 clear bit0", pc_out, 8'h08);
    bus_wr(2'b11, 8'h0B); chk("R5 set bit5", pc_out, 8'h28);
    chk("R5 A untouched", pa_out, 8'h3C);
  endtask

  task automatic t_clear;
    bus_wr(2'b11, 8'h80);
    chk("R4 pa_out", pa_out, 8'h00);
    chk("R4 pb_out", pb_out, 8'h00);
    chk("R4 pc_out", pc_out, 8'h00);
  endtask

  task automatic t_split;
    logic [7:0] d;
    bus_wr(2'b11, 8'h88);
    chk("R3 split pc_oe", pc_oe, 8'h0F);
    bus_wr(2'b10, 8'hA5);
    chk("R7 C latch", pc_out, 8'hA5);
    bus_rd(2'b10, d); chk("R6 C split read", d, 8'h35);
    bus_rd(2'b11, d); chk("R8 ctl read 88", d, 8'h88);
    bus_wr(2'b11, 8'h92);
    chk("R3 A in", pa_oe, 8'h00);
    chk("R3 B in", pb_oe, 8'h00);
    chk("R3 C out", pc_oe, 8'hFF);
    bus_rd(2'b11, d); chk("R8 ctl read 92", d, 8'h92);
    bus_wr(2'b00, 8'h77);
    chk("R7 A not driven", pa_oe, 8'h00);
    bus_rd(2'b00, d); chk("R6 A pins not latch", d, 8'h5A);
    bus_rd(2'b01, d); chk("R6 B pins", d, 8'hE1);
  endtask

  task automatic t_nocs;
    logic [7:0] d;
    bus_wr(2'b11, 8'h80);
    bus_wr(2'b00, 8'h11);
    bus_wr(2'b00, 8'hEE, 1'b0);
    chk("R9 A kept", pa_out, 8'h11);
    bus_wr(2'b11, 8'h9B, 1'b0);
    chk("R9 dir kept", pa_oe, 8'hFF);
    bus_rd(2'b00, d, 1'b0); chk("R9 rdata idle", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_all_out();
    t_bits();
    t_clear();
    t_split();
    t_nocs();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule